// File: doc/BRIEF.md
# Match Timer Counter

This block is a 32-bit up-counting timer that software reaches through a simple synchronous register bus. A prescaler divides the clock before it reaches the main count. One compare channel watches the count. When the count reaches the compare value on a count tick, the channel can raise an interrupt flag, reload the count with zero, and clear the run enable. These three actions are selected independently. Used with no compare actions, the count serves as a free-running time base. Used with reload, it gives a periodic tick. Used with stop, it gives a one-shot delay.

Run control is a four-state machine whose state is the pair {hold, enable}. The states are `ST_IDLE` (stopped), `ST_RUN` (counting), `ST_HOLD` (count forced to zero, stopped) and `ST_HOLD_ARM` (count forced to zero, runs once the hold is released). A write to the control register moves the machine to the state written. This is the "software write" transition, and it is allowed from every state. The only other transition is "stop on match", from `ST_RUN` to `ST_IDLE`. It is taken when a compare hit occurs with the stop action selected and no control write is in the same cycle.

Top module: `mtim_top`

## Requirements
- R1: After reset every register reads 0, and `irq` is low.
- R2: Control register at offset 0x04. Bit 0 is the run enable and bit 1 is the hold. While hold is set, the count and the prescale counter are forced to 0 from the next edge on. Both bits read back.
- R3: Prescale value P is at offset 0x0C and is 32 bits wide. While the timer runs, an internal prescale counter advances once per clock. On the clock where it is at or above P, it returns to 0 and the count advances by one. The count therefore advances once every P+1 clocks, and P=0 gives one step per clock.
- R4: Compare control is at offset 0x14. When its bit 0 is set, a count tick that finds the count equal to the compare value (offset 0x18) sets flag bit 0 at offset 0x00. `irq` is high exactly while that flag is 1. Without bit 0, a hit leaves the flag alone.
- R5: When compare control bit 1 is set, a hit tick loads 0 into the count instead of incrementing it. With compare value M this gives a period of M+1 ticks.
- R6: When compare control bit 2 is set, a hit tick clears the run enable. The count stays at the compare value, or becomes 0 if bit 1 is also set.
- R7: Writing 1 to flag bit 0 clears it, and writing 0 leaves it unchanged. If a hit sets the flag on the same edge as a clearing write, the flag stays 1.
- R8: The count at offset 0x08 can be written by software. Without the reload action it wraps from 0xFFFFFFFF to 0. Once the enable is 0, the count holds its value.
- R9: Count-mode register at offset 0x70 is 2 bits wide. Only the value 0 lets the count advance. Any other value freezes the count even while the enable is set.
- R10: Unused register bits read 0 and ignore writes. Addresses outside the seven listed offsets read 0, and writes to them have no effect.
- R11: A read (`bus_sel`=1, `bus_wr`=0) returns the current register value in the same cycle. `bus_rdata` is 0 when no read is in progress. A write takes effect at the clock edge that ends the access cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| irq | output | 1 | Level interrupt, follows flag bit 0 |

## Verification
The hardest situation to reach is a clearing write to the flag that lands on the exact edge where a compare hit sets it again. The two timings are normally unrelated. The stimulus first holds the count at zero, then releases it with a one-clock prescale and a small compare value. It then counts bus cycles from the enable write, so that the write-one-to-clear falls on the second hit edge. A clear one cycle later then shows that the flag really can be cleared. One-shot stopping and the wrap from the all-ones count are reached the same way. The bench preloads the count or the compare value and then reads the count on every cycle around the event.

// File: rtl/mtim_pkg.sv
package mtim_pkg;

    // Byte offsets of the registers
    localparam int unsigned OFS_FLAG = 32'h000;
    localparam int unsigned OFS_CTRL = 32'h004;
    localparam int unsigned OFS_CNT  = 32'h008;
    localparam int unsigned OFS_PRE  = 32'h00C;
    localparam int unsigned OFS_MCTL = 32'h014;
    localparam int unsigned OFS_MVAL = 32'h018;
    localparam int unsigned OFS_MODE = 32'h070;

    // Compare control bit positions
    localparam int unsigned MC_IRQ  = 0;
    localparam int unsigned MC_LOAD = 1;
    localparam int unsigned MC_STOP = 2;
    localparam int unsigned MC_W    = 3;

    // Run state, encoded as {hold, enable}
    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_RUN      = 2'b01,
        ST_HOLD     = 2'b10,
        ST_HOLD_ARM = 2'b11
    } run_state_e;

    // One write strobe per register
    typedef struct packed {
        logic flag;
        logic ctrl;
        logic cnt;
        logic pre;
        logic mctl;
        logic mval;
        logic mode;
    } wr_strobe_t;

endpackage

// File: rtl/mtim_bus.sv
module mtim_bus
    import mtim_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned MODE_W = 2
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              flag,
    input  logic              en,
    input  logic              hold,
    input  logic [DATA_W-1:0] cnt,
    input  logic [DATA_W-1:0] pre_val,
    input  logic [MC_W-1:0]   mctl,
    input  logic [DATA_W-1:0] mval,
    input  logic [MODE_W-1:0] mode,
    output wr_strobe_t        stb,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(OFS_FLAG);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
    localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(OFS_PRE);
    localparam logic [ADDR_W-1:0] A_MCTL = ADDR_W'(OFS_MCTL);
    localparam logic [ADDR_W-1:0] A_MVAL = ADDR_W'(OFS_MVAL);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);

    logic do_wr;
    logic do_rd;

    assign do_wr = sel & wr;
    assign do_rd = sel & ~wr;

    // Write decode
    always_comb begin
        stb = '0;
        if (do_wr) begin
            case (addr)
                A_FLAG:  stb.flag = 1'b1;
                A_CTRL:  stb.ctrl = 1'b1;
                A_CNT:   stb.cnt  = 1'b1;
                A_PRE:   stb.pre  = 1'b1;
                A_MCTL:  stb.mctl = 1'b1;
                A_MVAL:  stb.mval = 1'b1;
                A_MODE:  stb.mode = 1'b1;
                default: stb      = '0;
            endcase
        end
    end

    // Read mux, zero outside a read
    always_comb begin
        rdata = '0;
        if (do_rd) begin
            case (addr)
                A_FLAG:  rdata = DATA_W'(flag);
                A_CTRL:  rdata = DATA_W'({hold, en});
                A_CNT:   rdata = cnt;
                A_PRE:   rdata = pre_val;
                A_MCTL:  rdata = DATA_W'(mctl);
                A_MVAL:  rdata = mval;
                A_MODE:  rdata = DATA_W'(mode);
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mtim_run_fsm.sv
module mtim_run_fsm
    import mtim_pkg::*;
#(
    parameter int unsigned MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [1:0]        ctrl_bits,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_bits,
    input  logic              stop_evt,
    output logic              en,
    output logic              hold,
    output logic [MODE_W-1:0] mode,
    output logic              advance
);

    run_state_e        state_q;
    run_state_e        state_d;
    logic [MODE_W-1:0] mode_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a software write wins over stop on match
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = ST_IDLE;
            ST_RUN:      state_d = stop_evt ? ST_IDLE : ST_RUN;
            ST_HOLD:     state_d = ST_HOLD;
            ST_HOLD_ARM: state_d = ST_HOLD_ARM;
        endcase
        if (ctrl_wr) begin
            state_d = run_state_e'(ctrl_bits);
        end
    end

    // Count-mode register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr) begin
            mode_q <= mode_bits;
        end
    end

    // Outputs
    always_comb begin
        en      = 1'b0;
        hold    = 1'b0;
        advance = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                en   = 1'b0;
                hold = 1'b0;
            end
            ST_RUN: begin
                en      = 1'b1;
                advance = (mode_q == '0);
            end
            ST_HOLD: begin
                hold = 1'b1;
            end
            ST_HOLD_ARM: begin
                en   = 1'b1;
                hold = 1'b1;
            end
        endcase
    end

    assign mode = mode_q;

endmodule

// File: rtl/mtim_prescale.sv
module mtim_prescale #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         hold,
    input  logic         pre_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pre_val,
    output logic         tick
);

    logic [W-1:0] pre_val_q;
    logic [W-1:0] pre_cnt_q;

    // Prescale value register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_val_q <= '0;
        end else if (pre_wr) begin
            pre_val_q <= wdata;
        end
    end

    // At-or-above compare keeps a lowered limit from a long wrap
    assign tick = advance && (pre_cnt_q >= pre_val_q);

    // Prescale counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt_q <= '0;
        end else if (hold) begin
            pre_cnt_q <= '0;
        end else if (advance) begin
            pre_cnt_q <= tick ? '0 : pre_cnt_q + W'(1);
        end
    end

    assign pre_val = pre_val_q;

endmodule

// File: rtl/mtim_count.sv
module mtim_count
    import mtim_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            hold,
    input  logic            cnt_wr,
    input  logic            mval_wr,
    input  logic            mctl_wr,
    input  logic            flag_wr,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    cnt,
    output logic [W-1:0]    mval,
    output logic [MC_W-1:0] mctl,
    output logic            flag,
    output logic            stop_evt
);

    logic [W-1:0]    cnt_q;
    logic [W-1:0]    mval_q;
    logic [MC_W-1:0] mctl_q;
    logic            flag_q;
    logic            hit;
    logic            set_evt;
    logic            clr_req;
    logic [W-1:0]    cnt_step;

    assign hit      = tick && (cnt_q == mval_q);
    assign set_evt  = hit && mctl_q[MC_IRQ];
    assign stop_evt = hit && mctl_q[MC_STOP];
    assign clr_req  = flag_wr && wdata[0];

    // Value the count takes on a tick
    always_comb begin
        if (hit && mctl_q[MC_LOAD]) begin
            cnt_step = '0;
        end else if (hit && mctl_q[MC_STOP]) begin
            cnt_step = cnt_q;
        end else begin
            cnt_step = cnt_q + W'(1);
        end
    end

    // Count: hold, then software write, then tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hold) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wdata;
        end else if (tick) begin
            cnt_q <= cnt_step;
        end
    end

    // Compare value and compare control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mval_q <= '0;
            mctl_q <= '0;
        end else begin
            if (mval_wr) begin
                mval_q <= wdata;
            end
            if (mctl_wr) begin
                mctl_q <= wdata[MC_W-1:0];
            end
        end
    end

    // Flag: a set beats a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_evt) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    assign cnt  = cnt_q;
    assign mval = mval_q;
    assign mctl = mctl_q;
    assign flag = flag_q;

endmodule

// File: rtl/mtim_top.sv
module mtim_top
    import mtim_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    wr_strobe_t        stb_w;
    logic              en_w;
    logic              hold_w;
    logic [MODE_W-1:0] mode_w;
    logic              adv_w;
    logic              tick_w;
    logic [CNT_W-1:0]  pre_val_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  mval_w;
    logic [MC_W-1:0]   mctl_w;
    logic              flag_w;
    logic              stop_w;

    mtim_bus #(
        .ADDR_W (ADDR_W),
        .DATA_W (CNT_W),
        .MODE_W (MODE_W)
    ) bus_i (
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .flag    (flag_w),
        .en      (en_w),
        .hold    (hold_w),
        .cnt     (cnt_w),
        .pre_val (pre_val_w),
        .mctl    (mctl_w),
        .mval    (mval_w),
        .mode    (mode_w),
        .stb     (stb_w),
        .rdata   (bus_rdata)
    );

    mtim_run_fsm #(
        .MODE_W (MODE_W)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (stb_w.ctrl),
        .ctrl_bits (bus_wdata[1:0]),
        .mode_wr   (stb_w.mode),
        .mode_bits (bus_wdata[MODE_W-1:0]),
        .stop_evt  (stop_w),
        .en        (en_w),
        .hold      (hold_w),
        .mode      (mode_w),
        .advance   (adv_w)
    );

    mtim_prescale #(
        .W (CNT_W)
    ) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (adv_w),
        .hold    (hold_w),
        .pre_wr  (stb_w.pre),
        .wdata   (bus_wdata),
        .pre_val (pre_val_w),
        .tick    (tick_w)
    );

    mtim_count #(
        .W (CNT_W)
    ) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_w),
        .hold     (hold_w),
        .cnt_wr   (stb_w.cnt),
        .mval_wr  (stb_w.mval),
        .mctl_wr  (stb_w.mctl),
        .flag_wr  (stb_w.flag),
        .wdata    (bus_wdata),
        .cnt      (cnt_w),
        .mval     (mval_w),
        .mctl     (mctl_w),
        .flag     (flag_w),
        .stop_evt (stop_w)
    );

    assign irq = flag_w;

endmodule

// File: rtl/mtim_chk.sv
module mtim_chk #(
    parameter int unsigned W      = 32,
    parameter int unsigned MODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [W-1:0]      cnt,
    input logic [W-1:0]      mval,
    input logic [2:0]        mctl,
    input logic              en,
    input logic              hold,
    input logic [MODE_W-1:0] mode,
    input logic              ctrl_wr,
    input logic              cnt_wr,
    input logic              flag_wr,
    input logic              wbit0,
    input logic              irq
);

    logic hit;
    assign hit = tick && (cnt == mval);

    AST_HOLD_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0)); // R2

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (en && !hold && mode == '0)); // R3

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit && mctl[0])); // R4

    AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mctl[1] && !cnt_wr && !hold) |=> (cnt == '0)); // R5

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mctl[2] && !ctrl_wr) |=> !en); // R6

    AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && wbit0 && !(hit && mctl[0])) |=> !irq); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mctl[0]) |=> irq); // R7

    AST_MODE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != '0 && !cnt_wr && !hold) |=> $stable(cnt)); // R9

endmodule

bind mtim_top mtim_chk #(
    .W      (CNT_W),
    .MODE_W (MODE_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .cnt     (cnt_w),
    .mval    (mval_w),
    .mctl    (mctl_w),
    .en      (en_w),
    .hold    (hold_w),
    .mode    (mode_w),
    .ctrl_wr (stb_w.ctrl),
    .cnt_wr  (stb_w.cnt),
    .flag_wr (stb_w.flag),
    .wbit0   (bus_wdata[0]),
    .irq     (irq)
);

// File: tb/mtim_top_tb_top.sv
`timescale 1ns/1ps
module mtim_top_tb_top;

    localparam logic [7:0] A_FLAG = 8'h00;
    localparam logic [7:0] A_CTRL = 8'h04;
    localparam logic [7:0] A_CNT  = 8'h08;
    localparam logic [7:0] A_PRE  = 8'h0C;
    localparam logic [7:0] A_MCTL = 8'h14;
    localparam logic [7:0] A_MVAL = 8'h18;
    localparam logic [7:0] A_MODE = 8'h70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    mtim_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic note(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops an expected item for each scoreboarded read
    always @(negedge clk) begin
        if (rst_n && bus_sel && !bus_wr && sb_q.size() != 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            note(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
        end
    end

    // Driver tasks: each call occupies one bus cycle
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic rd_val(input logic [7:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_wdata = '0;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        note(irq === e, tag, 32'(irq), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        rd(A_FLAG, 0, "R1 flag"); rd(A_CTRL, 0, "R1 ctrl");
        rd(A_CNT, 0, "R1 count"); rd(A_PRE, 0, "R1 prescale");
        rd(A_MCTL, 0, "R1 mctl"); rd(A_MVAL, 0, "R1 mval");
        rd(A_MODE, 0, "R1 mode");
        chk_irq(1'b0, "R1 irq");

        // R3 / R11: free-run with prescale 0, one step per clock
        wr(A_CTRL, 1);
        for (int k = 0; k < 6; k++) rd(A_CNT, 32'(k), "R3 free run");

        // R2: hold forces zero
        wr(A_CTRL, 3);
        rd(A_CTRL, 3, "R2 ctrl readback");
        rd(A_CNT, 0, "R2 held zero");
        idle(); idle();
        rd(A_CNT, 0, "R2 still zero");

        // R3: prescale 2 gives one step per three clocks
        wr(A_PRE, 2);
        wr(A_CTRL, 1);
        for (int k = 0; k < 9; k++) rd(A_CNT, 32'(k / 3), "R3 prescale");
        wr(A_CTRL, 2);

        // R4 / R5: periodic with interrupt, compare value 4
        wr(A_PRE, 0); wr(A_MVAL, 4); wr(A_MCTL, 3);
        wr(A_CTRL, 1);
        for (int k = 0; k < 12; k++) rd(A_CNT, 32'(k % 5), "R5 period");
        rd(A_FLAG, 1, "R4 flag set");
        chk_irq(1'b1, "R4 irq high");
        wr(A_CTRL, 2);
        wr(A_FLAG, 0);
        rd(A_FLAG, 1, "R7 write zero ignored");
        wr(A_FLAG, 1);
        rd(A_FLAG, 0, "R7 cleared");
        chk_irq(1'b0, "R4 irq low");

        // R5 / R4: reload without interrupt leaves the flag clear
        wr(A_MCTL, 2);
        wr(A_CTRL, 1);
        for (int k = 0; k < 10; k++) rd(A_CNT, 32'(k % 5), "R5 reload only");
        rd(A_FLAG, 0, "R4 no flag without bit 0");
        wr(A_CTRL, 2);

        // R7: clear on the same edge as a hit, then a clean clear
        wr(A_MVAL, 3); wr(A_MCTL, 3);
        wr(A_CTRL, 1);
        for (int k = 0; k < 7; k++) idle();
        wr(A_FLAG, 1);
        rd(A_FLAG, 1, "R7 set wins");
        wr(A_FLAG, 1);
        rd(A_FLAG, 0, "R7 clear off-hit");
        rd(A_CNT, 3, "R7 count after clears");
        wr(A_CTRL, 2); wr(A_FLAG, 1);

        // R6: one-shot stops at the compare value
        wr(A_MCTL, 5); wr(A_MVAL, 3);
        wr(A_CTRL, 1);
        for (int k = 0; k < 8; k++) rd(A_CNT, (k < 3) ? 32'(k) : 32'd3, "R6 one-shot");
        rd(A_CTRL, 0, "R6 enable cleared");
        rd(A_FLAG, 1, "R6 flag");

        // R6: one-shot with reload ends at zero
        wr(A_FLAG, 1); wr(A_CTRL, 2); wr(A_MCTL, 6);
        wr(A_CTRL, 1);
        for (int k = 0; k < 7; k++) rd(A_CNT, (k <= 3) ? 32'(k) : 32'd0, "R6 one-shot reload");
        rd(A_CTRL, 0, "R6 reload enable cleared");
        rd(A_FLAG, 0, "R6 no flag without bit 0");

        // R8: software load and wrap
        wr(A_CTRL, 0); wr(A_MCTL, 0);
        wr(A_CNT, 32'hFFFF_FFFE);
        wr(A_CTRL, 1);
        rd(A_CNT, 32'hFFFF_FFFE, "R8 loaded");
        rd(A_CNT, 32'hFFFF_FFFF, "R8 top");
        rd(A_CNT, 32'h0, "R8 wrap");
        rd(A_CNT, 32'h1, "R8 after wrap");
        wr(A_CTRL, 0);
        rd_val(A_CNT, v);
        idle(); idle(); idle();
        rd(A_CNT, v, "R8 stopped holds");

        // R9: non-zero mode freezes the count
        wr(A_MODE, 1);
        wr(A_CTRL, 1);
        rd(A_MODE, 1, "R9 mode readback");
        rd_val(A_CNT, v);
        idle(); idle(); idle();
        rd(A_CNT, v, "R9 frozen");
        wr(A_MODE, 0);
        rd_val(A_CNT, v);
        rd(A_CNT, v + 1, "R9 resumes");

        // R10: unused bits and unmapped addresses
        wr(A_CTRL, 0);
        wr(A_MCTL, 32'hFFFF_FFFF);
        rd(A_MCTL, 7, "R10 mctl width");
        wr(A_MODE, 32'hFFFF_FFFF);
        rd(A_MODE, 3, "R10 mode width");
        wr(A_MODE, 0);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 0, "R10 unmapped read");
        rd(8'h74, 0, "R10 unmapped read 2");
        wr(A_PRE, 32'hFFFF_FFFF);
        rd(A_PRE, 32'hFFFF_FFFF, "R3 prescale full width");
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, 3, "R10 ctrl width");
        wr(A_CTRL, 0);

        // R11: no read, zero read data
        idle();
        @(negedge clk);
        note(bus_rdata === 32'h0, "R11 idle rdata", bus_rdata, 32'h0);

        idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule